// File: doc/BRIEF.md
# Wake Event Status Latch

This block watches five asynchronous wake sources and records each occurrence in a sticky 8-bit status register. The sources are two serial receive-data lines, an active-low ring indicator, a consumer-IR wake strobe and a push button. Each pin passes through a synchronizer, and an edge detector then raises a one-cycle event. That event sets the bit for its source. The bit stays set until the host reads the register at its index.

The power-management side sees an active-low power-on request. The request is driven by the receive-data, ring and IR bits, each gated by an enable bit in the same bit position. The button bit is recorded for software but never drives the request. The enable mask comes from a neighbouring block through an input port.

Top module: `wake_status_latch`

## Requirements
- R1: After reset the status register reads 0x00 and `power_on_no` is 1.
- R2: A high-to-low transition on `rxa_i` sets status bit 0. A low-to-high transition on the same pin sets nothing.
- R3: A high-to-low transition on `rxb_i` sets status bit 1.
- R4: A high-to-low transition on `ring_ni` (ring asserted) sets status bit 3.
- R5: A low-to-high transition on `ir_wake_i` sets status bit 5.
- R6: A low-to-high transition on `button_i` sets status bit 2. Bit 2 never pulls `power_on_no` low, whatever `wake_en_i` holds.
- R7: Bits 4, 6 and 7 of the register always read 0.
- R8: A read (`reg_rd_i` high with `reg_addr_i` equal to `REG_INDEX`) returns the status held before the access and clears every bit at the next clock edge. A read at any other index returns 0x00 and clears nothing.
- R9: An event whose detection falls in the same cycle as a clearing read leaves its bit set after that read.
- R10: A host write (`reg_wr_i`) to the register index changes no status bit.
- R11: `power_on_no` is 0 exactly when at least one of status bits 0, 1, 3 or 5 is 1 and the `wake_en_i` bit in the same position is 1.
- R12: With `SYNC_STAGES` = 2, a pin change driven before clock edge k shows up in the status register after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxa_i | input | 1 | First serial receive-data line, idles high |
| rxb_i | input | 1 | Second serial receive-data line, idles high |
| ring_ni | input | 1 | Ring indicator, active low |
| ir_wake_i | input | 1 | Consumer-IR wake strobe, active high |
| button_i | input | 1 | Push button, active high |
| reg_addr_i | input | ADDR_W | Host register index |
| reg_rd_i | input | 1 | Host read strobe |
| reg_wr_i | input | 1 | Host write strobe |
| reg_wdata_i | input | 8 | Host write data (ignored by this register) |
| reg_rdata_o | output | 8 | Host read data |
| wake_en_i | input | 8 | Per-bit wake enables, aligned with the status bits |
| power_on_no | output | 1 | Active-low power-on request |

## Verification
The bench builds the block with its defaults: `REG_INDEX` = 0xB3, `ADDR_W` = 8 and `SYNC_STAGES` = 2. With these values the pin-to-status latency is three edges. That lets the bench place a clearing read exactly in the cycle where a synchronized edge is detected. It also lets the bench watch `power_on_no` on the edge before and the edge after a bit latches. Reads at the neighbouring index 0xB2 exercise the decode path without clearing anything.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned STAT_W = 8;

  localparam int unsigned BIT_RXA  = 0;
  localparam int unsigned BIT_RXB  = 1;
  localparam int unsigned BIT_BTN  = 2;
  localparam int unsigned BIT_RING = 3;
  localparam int unsigned BIT_IR   = 5;

  // implemented status bits
  localparam logic [STAT_W-1:0] IMPL_MASK = 8'h2F;
  // bits allowed to raise the power-on request (button excluded)
  localparam logic [STAT_W-1:0] WAKE_MASK = 8'h2B;
  // channels that fire on a rising edge; others on a falling edge
  localparam logic [STAT_W-1:0] RISE_MASK = 8'h24;
  // idle pin level, used as synchronizer reset value
  localparam logic [STAT_W-1:0] IDLE_LVL  = 8'h0B;
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          RISE        = 1'b0,
  parameter bit          IDLE        = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic evt_o
);
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {CHAIN_W{IDLE}};
    else         chain_q <= {chain_q[CHAIN_W-2:0], pin_i};
  end

  // chain_q[SYNC_STAGES-1] is the synchronized level, chain_q[SYNC_STAGES] one cycle older
  generate
    if (RISE) begin : g_rise
      assign evt_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    end else begin : g_fall
      assign evt_o = ~chain_q[SYNC_STAGES-1] & chain_q[SYNC_STAGES];
    end
  endgenerate
endmodule

// File: rtl/wake_status_reg.sv
module wake_status_reg #(
  parameter int unsigned           W    = 8,
  parameter logic [W-1:0]          IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, stat_d;

  // set wins over clear so a coincident event survives the read
  always_comb begin
    stat_d = clr_i ? '0 : stat_q;
    stat_d = (stat_d | evt_i) & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/wake_host_if.sv
module wake_host_if #(
  parameter int unsigned        ADDR_W    = 8,
  parameter int unsigned        W         = 8,
  parameter logic [ADDR_W-1:0]  REG_INDEX = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [W-1:0]      stat_i,
  output logic              clr_o,
  output logic [W-1:0]      rdata_o
);
  logic hit;

  assign hit     = (addr_i == REG_INDEX);
  assign clr_o   = rd_i & hit;
  assign rdata_o = clr_o ? stat_i : '0;
endmodule

// File: rtl/wake_status_latch.sv
module wake_status_latch
  import wake_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_INDEX   = 8'hB3,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxa_i,
  input  logic              rxb_i,
  input  logic              ring_ni,
  input  logic              ir_wake_i,
  input  logic              button_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [7:0]        wake_en_i,
  output logic              power_on_no
);
  logic [STAT_W-1:0] pins;
  logic [STAT_W-1:0] evt_vec;
  logic [STAT_W-1:0] status_q;
  logic              clr;
  logic              unused_wr;

  // status writes are deliberately discarded
  assign unused_wr = reg_wr_i ^ (^reg_wdata_i);

  always_comb begin
    pins           = IDLE_LVL;
    pins[BIT_RXA]  = rxa_i;
    pins[BIT_RXB]  = rxb_i;
    pins[BIT_BTN]  = button_i;
    pins[BIT_RING] = ring_ni;
    pins[BIT_IR]   = ir_wake_i;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_chan
    if (IMPL_MASK[i]) begin : g_det
      wake_edge_det #(
        .SYNC_STAGES (SYNC_STAGES),
        .RISE        (RISE_MASK[i]),
        .IDLE        (IDLE_LVL[i])
      ) u_det (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (pins[i]),
        .evt_o (evt_vec[i])
      );
    end else begin : g_none
      assign evt_vec[i] = 1'b0;
    end
  end

  wake_status_reg #(
    .W    (STAT_W),
    .IMPL (IMPL_MASK)
  ) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_vec),
    .clr_i (clr),
    .stat_o(status_q)
  );

  wake_host_if #(
    .ADDR_W   (ADDR_W),
    .W        (STAT_W),
    .REG_INDEX(REG_INDEX)
  ) u_host (
    .addr_i (reg_addr_i),
    .rd_i   (reg_rd_i),
    .stat_i (status_q),
    .clr_o  (clr),
    .rdata_o(reg_rdata_o)
  );

  assign power_on_no = ~|(status_q & wake_en_i & WAKE_MASK);
endmodule

// File: rtl/wake_status_chk.sv
module wake_status_chk #(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REG_INDEX = 8'hB3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [7:0]        reg_rdata_o,
  input logic [7:0]        wake_en_i,
  input logic              power_on_no,
  input logic [7:0]        status_q,
  input logic [7:0]        evt_vec
);
  logic rd_hit;
  assign rd_hit = reg_rd_i && (reg_addr_i == REG_INDEX);

  p_reserved_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & 8'hD0) == 8'h00 && (reg_rdata_o & 8'hD0) == 8'h00);

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> (status_q & ~$past(evt_vec)) == 8'h00);

  p_miss_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |-> reg_rdata_o == 8'h00);

  p_event_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vec & 8'h2F) != 8'h00 |=> (status_q & $past(evt_vec & 8'h2F)) == $past(evt_vec & 8'h2F));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> (status_q & $past(status_q)) == $past(status_q));

  p_write_no_effect_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !rd_hit && evt_vec == 8'h00) |=> $stable(status_q));

  p_button_no_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & 8'hFB) == 8'h00 |-> power_on_no);

  p_wake_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_q & wake_en_i & 8'h2B)) |-> !power_on_no);

  p_wake_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_q & wake_en_i & 8'h2B)) |-> power_on_no);
endmodule

bind wake_status_latch wake_status_chk #(
  .ADDR_W   (ADDR_W),
  .REG_INDEX(REG_INDEX)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_rd_i   (reg_rd_i),
  .reg_wr_i   (reg_wr_i),
  .reg_rdata_o(reg_rdata_o),
  .wake_en_i  (wake_en_i),
  .power_on_no(power_on_no),
  .status_q   (status_q),
  .evt_vec    (evt_vec)
);

// File: tb/tb_wake_status_latch.sv
`timescale 1ns/1ps
module tb_wake_status_latch;
  localparam logic [7:0] IDX = 8'hB3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxa_i = 1'b1, rxb_i = 1'b1, ring_ni = 1'b1;
  logic       ir_wake_i = 1'b0, button_i = 1'b0;
  logic [7:0] reg_addr_i = '0;
  logic       reg_rd_i = 1'b0, reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [7:0] wake_en_i = '0;
  logic       power_on_no;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  wake_status_latch dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxa_i(rxa_i), .rxb_i(rxb_i),
    .ring_ni(ring_ni), .ir_wake_i(ir_wake_i), .button_i(button_i),
    .reg_addr_i(reg_addr_i), .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .wake_en_i(wake_en_i), .power_on_no(power_on_no)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk_i);
    reg_addr_i = a;
    reg_rd_i   = 1'b1;
    #1 v = reg_rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i  = IDX;
    reg_wdata_i = d;
    reg_wr_i    = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk({7'd0, power_on_no}, 8'h01, "R1 power_on_no after reset");
    host_read(IDX, v);
    chk(v, 8'h00, "R1 status after reset");
  endtask

  task automatic t_rxa_latency();
    logic [7:0] v;
    wake_en_i = 8'h01;
    @(negedge clk_i);
    rxa_i = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk({7'd0, power_on_no}, 8'h01, "R12 not latched after two edges");
    @(posedge clk_i);
    @(negedge clk_i);
    chk({7'd0, power_on_no}, 8'h00, "R12 latched on third edge");
    host_read(IDX, v);
    chk(v, 8'h01, "R2 falling rxa sets bit 0");
    @(negedge clk_i);
    rxa_i = 1'b1;
    settle(5);
    host_read(IDX, v);
    chk(v, 8'h00, "R2 rising rxa ignored");
    wake_en_i = 8'h00;
  endtask

  task automatic t_rxb();
    logic [7:0] v;
    wake_en_i = 8'h02;
    @(negedge clk_i);
    rxb_i = 1'b0;
    settle(4);
    chk({7'd0, power_on_no}, 8'h00, "R11 rxb enabled wake");
    host_read(IDX, v);
    chk(v, 8'h02, "R3 falling rxb sets bit 1");
    chk({7'd0, power_on_no}, 8'h01, "R11 request released after clear");
    rxb_i = 1'b1;
    settle(4);
    wake_en_i = 8'h00;
  endtask

  task automatic t_ring_ir();
    logic [7:0] v;
    wake_en_i = 8'hD7; // bit 3 and 5 disabled
    @(negedge clk_i);
    ring_ni = 1'b0;
    ir_wake_i = 1'b1;
    settle(4);
    chk({7'd0, power_on_no}, 8'h01, "R11 disabled bits give no request");
    wake_en_i = 8'h20;
    #1 chk({7'd0, power_on_no}, 8'h00, "R11 ir enable alone requests");
    host_read(IDX, v);
    chk(v & 8'h08, 8'h08, "R4 ring assertion sets bit 3");
    chk(v & 8'h20, 8'h20, "R5 ir wake sets bit 5");
    ring_ni = 1'b1;
    ir_wake_i = 1'b0;
    settle(4);
    host_read(IDX, v);
    chk(v, 8'h00, "R4 R5 release edges ignored");
    wake_en_i = 8'h00;
  endtask

  task automatic t_button();
    logic [7:0] v;
    wake_en_i = 8'hFF;
    @(negedge clk_i);
    button_i = 1'b1;
    settle(4);
    chk({7'd0, power_on_no}, 8'h01, "R6 button never requests power");
    host_read(IDX, v);
    chk(v, 8'h04, "R6 button sets bit 2");
    button_i = 1'b0;
    settle(4);
    wake_en_i = 8'h00;
  endtask

  task automatic t_all_write();
    logic [7:0] v;
    host_write(8'hFF);
    host_read(IDX, v);
    chk(v, 8'h00, "R10 write cannot set bits");
    @(negedge clk_i);
    rxa_i = 1'b0; rxb_i = 1'b0; ring_ni = 1'b0; ir_wake_i = 1'b1; button_i = 1'b1;
    settle(4);
    host_write(8'h00);
    host_read(IDX, v);
    chk(v, 8'h2F, "R10 write cannot clear bits");
    chk(v & 8'hD0, 8'h00, "R7 reserved bits read zero");
    rxa_i = 1'b1; rxb_i = 1'b1; ring_ni = 1'b1; ir_wake_i = 1'b0; button_i = 1'b0;
    settle(4);
  endtask

  task automatic t_index();
    logic [7:0] v;
    @(negedge clk_i);
    rxa_i = 1'b0;
    settle(4);
    host_read(8'hB2, v);
    chk(v, 8'h00, "R8 other index returns zero");
    host_read(IDX, v);
    chk(v, 8'h01, "R8 other index did not clear");
    host_read(IDX, v);
    chk(v, 8'h00, "R8 read cleared status");
    rxa_i = 1'b1;
    settle(4);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    @(negedge clk_i);
    ring_ni = 1'b0;
    settle(4);
    @(negedge clk_i);
    rxa_i = 1'b0;
    repeat (2) @(posedge clk_i);
    host_read(IDX, v);
    chk(v, 8'h08, "R9 read shows pre-clear value");
    host_read(IDX, v);
    chk(v, 8'h01, "R9 coincident event survives read");
    ring_ni = 1'b1; rxa_i = 1'b1;
    settle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    settle(1);
    t_reset();
    t_rxa_latency();
    t_rxb();
    t_ring_ir();
    t_button();
    t_all_write();
    t_index();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule